// File: doc/BRIEF.md
# Two-Cycle Flash Command Decoder

This block models the command register of a byte-wide parallel NOR flash. The external bus is sampled in the local clock domain and has active-low chip enable, output enable and write enable, a 17-bit address and an 8-bit data byte. A bus write happens while chip enable and write enable are both low. The block decodes each write as a one-cycle command or as part of a two-cycle sequence. It also picks what a read cycle returns: array contents, an identifier byte, or the array contents at an erase-verify address latched earlier.

The block changes no memory contents itself. When a two-cycle sequence completes, it sends a one-clock start pulse to a separate operation engine. The pulse comes with the captured address, the captured data and a flag that tells an automatic operation from a manual one. The engine reports back on `busy`. While `busy` is high, every command is dropped except the double reset. The array sits outside the block and is reached through a simple combinational read port (`arr_addr` out, `arr_data` in).

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (`rd_mode` = 0). No start pulse is high, and a read returns `arr_data` for the bus address.
- R2: A single write of 00H selects array read. `rd_mode` is 0 (array), 1 (identifier) or 2 (erase verify), and never 3.
- R3: After a write of 90H, reads return C2H when addr[0]=0 and 1AH when addr[0]=1.
- R4: 40H followed by a second write raises `prog_go` for one cycle. It comes with `op_auto`=1, `op_addr` set to the address of the second write and `op_data` set to its data, and the mode returns to array.
- R5: 30H then 30H raises `chip_erase_go` with `op_auto`=1. 20H then 20H raises it with `op_auto`=0.
- R6: 20H then D0H raises `block_erase_go` with `op_auto`=1. 60H then 60H raises it with `op_auto`=0. In both cases `op_addr` is the address of the second write.
- R7: A write of A0H latches its address. Later reads drive `arr_addr` with that address, whatever the bus address, and return its array byte.
- R8: FFH written on two consecutive writes returns the block to array read. A single FFH does not change the read mode.
- R9: A second write that does not match the pending first code starts nothing and returns the block to array read.
- R10: While `busy` is high, all writes are ignored. The one exception is FFH followed by FFH, which still resets to array read.
- R11: The address is captured in the first clock cycle in which chip enable and write enable are both low. The data is the last byte sampled before either of them goes high.
- R12: At most one start pulse is high in any cycle, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Bus address |
| din | input | 8 | Bus write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | High during a read cycle |
| rd_mode | output | 2 | 0 array, 1 identifier, 2 erase verify |
| arr_addr | output | 17 | Array read port address |
| arr_data | input | 8 | Array read port data |
| busy | input | 1 | Operation engine is running |
| prog_go | output | 1 | Start byte program (one cycle) |
| chip_erase_go | output | 1 | Start chip erase (one cycle) |
| block_erase_go | output | 1 | Start block erase (one cycle) |
| op_auto | output | 1 | Started operation is automatic |
| op_addr | output | 17 | Address for the started operation |
| op_data | output | 8 | Data for the started operation |

## Verification
The hardest case to reach is a pending first-cycle code that meets a different second byte, or that meets a busy engine. Such a sequence must leave no trace at all: no pulse, and no mode change other than the specified return to array read. The stimulus first puts the block in identifier mode, so that a later array-mode read shows whether the abort or the ignored write had any effect. The queue of expected pulses stays empty across these sequences, so any pulse that does appear is reported as unexpected. Each bus write also changes the address after its first cycle and presents junk data in its first cycle, so that capture at the wrong moment shows up in the pulse fields.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 17,
  parameter logic [7:0] MFR_ID = 8'hC2,
  parameter logic [7:0] DEV_ID = 8'h1A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic [1:0]    rd_mode,
  output logic [AW-1:0] arr_addr,
  input  logic [7:0]    arr_data,
  input  logic          busy,
  output logic          prog_go,
  output logic          chip_erase_go,
  output logic          block_erase_go,
  output logic          op_auto,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);
  localparam logic [1:0] M_ARRAY = 2'd0, M_ID = 2'd1, M_VERIFY = 2'd2;

  logic          wr_q;
  logic [AW-1:0] a_lat, v_addr;
  logic [7:0]    d_lat, pend_code;
  logic          pend_v;

  wire wr_act = !ce_n && !we_n;
  wire w_beg  = wr_act && !wr_q;
  wire w_end  = wr_q && !wr_act;

  assign dout_en  = !ce_n && !oe_n && we_n;
  assign arr_addr = (rd_mode == M_VERIFY) ? v_addr : addr;
  assign dout     = (rd_mode == M_ID) ? (addr[0] ? DEV_ID : MFR_ID) : arr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      a_lat <= '0;
      d_lat <= '0;
      v_addr <= '0;
      rd_mode <= M_ARRAY;
      pend_v <= 1'b0;
      pend_code <= '0;
      prog_go <= 1'b0;
      chip_erase_go <= 1'b0;
      block_erase_go <= 1'b0;
      op_auto <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      wr_q <= wr_act;
      if (w_beg) a_lat <= addr;
      if (wr_act) d_lat <= din;
      prog_go <= 1'b0;
      chip_erase_go <= 1'b0;
      block_erase_go <= 1'b0;
      if (w_end) begin
        if (busy) begin
          if (pend_v && pend_code == 8'hFF && d_lat == 8'hFF) begin
            rd_mode <= M_ARRAY;
            pend_v <= 1'b0;
          end else begin
            pend_v <= (d_lat == 8'hFF);
            pend_code <= d_lat;
          end
        end else if (pend_v) begin
          pend_v <= 1'b0;
          rd_mode <= M_ARRAY;
          case (pend_code)
            8'h40: begin
              prog_go <= 1'b1;
              op_auto <= 1'b1;
              op_addr <= a_lat;
              op_data <= d_lat;
            end
            8'h30: if (d_lat == 8'h30) begin
              chip_erase_go <= 1'b1;
              op_auto <= 1'b1;
            end
            8'h20: begin
              if (d_lat == 8'h20) begin
                chip_erase_go <= 1'b1;
                op_auto <= 1'b0;
              end else if (d_lat == 8'hD0) begin
                block_erase_go <= 1'b1;
                op_auto <= 1'b1;
                op_addr <= a_lat;
              end
            end
            8'h60: if (d_lat == 8'h60) begin
              block_erase_go <= 1'b1;
              op_auto <= 1'b0;
              op_addr <= a_lat;
            end
            default: ;
          endcase
        end else begin
          case (d_lat)
            8'h00: rd_mode <= M_ARRAY;
            8'h90: rd_mode <= M_ID;
            8'hA0: begin
              rd_mode <= M_VERIFY;
              v_addr <= a_lat;
            end
            8'h40, 8'h30, 8'h20, 8'h60, 8'hFF: begin
              pend_v <= 1'b1;
              pend_code <= d_lat;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module flash_cmd_decoder_chk #(
  parameter int AW = 17,
  parameter logic [7:0] MFR_ID = 8'hC2,
  parameter logic [7:0] DEV_ID = 8'h1A
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic [7:0]    dout,
  input logic [1:0]    rd_mode,
  input logic          busy,
  input logic          prog_go,
  input logic          chip_erase_go,
  input logic          block_erase_go
);
  wire any_go = prog_go || chip_erase_go || block_erase_go;

  assert_one_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, chip_erase_go, block_erase_go}));
  assert_prog_short_R12: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> !prog_go);
  assert_erase_short_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_erase_go || block_erase_go) |=> !(chip_erase_go || block_erase_go));
  assert_start_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |-> !$past(busy));
  assert_start_array_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_go |-> rd_mode == 2'd0);
  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode != 2'd3);
  assert_id_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd1 && !ce_n && !oe_n) |-> (dout == MFR_ID || dout == DEV_ID));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.AW(AW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dout(dout), .rd_mode(rd_mode),
  .busy(busy), .prog_go(prog_go), .chip_erase_go(chip_erase_go), .block_erase_go(block_erase_go)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout, arr_data, op_data;
  logic        dout_en, prog_go, chip_erase_go, block_erase_go, op_auto;
  logic [1:0]  rd_mode;
  logic [16:0] arr_addr, op_addr;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic        auto_f;
    logic [16:0] a;
    logic [7:0]  d;
    string       req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] amodel(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h5A;
  endfunction
  assign arr_data = amodel(arr_addr);

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .rd_mode(rd_mode), .arr_addr(arr_addr), .arr_data(arr_data),
    .busy(busy), .prog_go(prog_go), .chip_erase_go(chip_erase_go), .block_erase_go(block_erase_go),
    .op_auto(op_auto), .op_addr(op_addr), .op_data(op_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic au, input logic [16:0] a, input logic [7:0] d, input string req);
    exp_t e;
    e.kind = kind; e.auto_f = au; e.a = a; e.d = d; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = ~d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = ~a; din = d;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1; din = 8'h00;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [16:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #5;
    chk(dout_en && dout == exp, req, dout, exp);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard whenever a start pulse appears
  always @(negedge clk) begin
    if (rst_n && (prog_go || chip_erase_go || block_erase_go)) begin
      int kind;
      kind = prog_go ? 1 : (chip_erase_go ? 2 : 3);
      chk($countones({prog_go, chip_erase_go, block_erase_go}) == 1, "R12 one pulse",
          {prog_go, chip_erase_go, block_erase_go}, 0);
      if (q.size() == 0) begin
        chk(1'b0, "R9 R10 unexpected start pulse", kind, 0);
      end else begin
        exp_t e;
        bit ok;
        e = q.pop_front();
        ok = (kind == e.kind) && (op_auto == e.auto_f);
        if (kind != 2) ok = ok && (op_addr == e.a);
        if (kind == 1) ok = ok && (op_data == e.d);
        chk(ok, e.req, {kind, op_auto, op_addr, op_data}, {e.kind, e.auto_f, e.a, e.d});
      end
    end
  end

  // Follow-up: every pulse must be gone in the next cycle (R12)
  always @(negedge clk) begin
    if (rst_n && (prog_go || chip_erase_go || block_erase_go)) begin
      @(negedge clk);
      chk(!(prog_go || chip_erase_go || block_erase_go), "R12 pulse width", 1, 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!prog_go && !chip_erase_go && !block_erase_go && rd_mode == 2'd0, "R1 reset state",
        {rd_mode, prog_go, chip_erase_go, block_erase_go}, 0);
    rd(17'h00123, amodel(17'h00123), "R1 array read after reset");

    wr(17'h0, 8'h90);
    rd(17'h00000, 8'hC2, "R3 manufacturer id");
    rd(17'h1FFF1, 8'h1A, "R3 device id");
    wr(17'h0, 8'h00);
    rd(17'h1ABCD, amodel(17'h1ABCD), "R2 array read via 00H");

    push(1, 1'b1, 17'h0F0F0, 8'h3C, "R4 R11 program pulse");
    wr(17'h12345, 8'h40);
    wr(17'h0F0F0, 8'h3C);
    push(2, 1'b1, '0, '0, "R5 auto chip erase");
    wr(17'h0, 8'h30); wr(17'h0, 8'h30);
    push(2, 1'b0, '0, '0, "R5 manual chip erase");
    wr(17'h0, 8'h20); wr(17'h0, 8'h20);
    push(3, 1'b1, 17'h1C000, '0, "R6 auto block erase");
    wr(17'h0, 8'h20); wr(17'h1C000, 8'hD0);
    push(3, 1'b0, 17'h08000, '0, "R6 manual block erase");
    wr(17'h0, 8'h60); wr(17'h08000, 8'h60);

    wr(17'h05555, 8'hA0);
    rd(17'h00000, amodel(17'h05555), "R7 verify read");
    rd(17'h1FFFF, amodel(17'h05555), "R7 verify ignores bus address");
    chk(rd_mode == 2'd2, "R7 verify mode", rd_mode, 2);

    wr(17'h0, 8'h90);
    wr(17'h0, 8'hFF);
    rd(17'h00000, 8'hC2, "R8 single FFH keeps mode");
    wr(17'h0, 8'hFF);
    rd(17'h00001, amodel(17'h00001), "R8 double FFH reset");

    wr(17'h0, 8'h90);
    wr(17'h0, 8'h30); wr(17'h0, 8'h20);
    rd(17'h00001, amodel(17'h00001), "R9 mismatch aborts to array");
    wr(17'h0, 8'h20); wr(17'h0, 8'h33);
    chk(rd_mode == 2'd0, "R9 mode after abort", rd_mode, 0);

    wr(17'h0, 8'h90);
    @(negedge clk); busy = 1'b1;
    wr(17'h0, 8'h00);
    rd(17'h00000, 8'hC2, "R10 command ignored while busy");
    wr(17'h0, 8'h40); wr(17'h00005, 8'h05);
    wr(17'h0, 8'h30); wr(17'h0, 8'h30);
    rd(17'h00001, 8'h1A, "R10 sequences ignored while busy");
    wr(17'h0, 8'hFF); wr(17'h0, 8'hFF);
    rd(17'h00001, amodel(17'h00001), "R10 double FFH accepted while busy");
    @(negedge clk); busy = 1'b0;

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R4 R5 R6 missing start pulses", q.size(), 0);
    finish_run();
  end
endmodule